// File: doc/BRIEF.md
# Prioritised restart-vector interrupt controller with countdown timers

This block is the interrupt section of a serial and parallel I/O board that sits on an 8-bit processor bus. It has eight request sources: five countdown timers that the processor loads, an active-low sense input, the receive-ready and transmit-empty flags from the UART, and bit 7 of the parallel port. The parallel bit shares a slot with the fifth timer. An 8-bit mask chooses which sources may interrupt. The block then raises a single interrupt line and keeps the restart opcode of the winning source in an address register, which the processor can read.

When the processor runs its interrupt-acknowledge cycle, the block drives either that opcode or a fixed restart-7 opcode onto the bus. At the end of the cycle it clears the acknowledged timer request. A soft-reset bit in the command word stops all timers and drops the pending flag. The UART datapath and the printer port are outside this block, so their flags arrive here as plain inputs.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irqPending is 0, addrOut is 8'h00 and ackDrive is 0.
- R2: Writing a nonzero value N to a timer (wrAddr 0 to 4 for timers 1 to 5) makes that timer decrement on each cycle with tickEn high. Its request sets on the N-th such cycle. It then holds at zero until it is written again.
- R3: Mask bit i (written at wrAddr 5) enables source slot i. A source whose mask bit is clear never raises irqPending or alters addrOut. irqPending and addrOut follow the requests with one register stage.
- R4: The source slots, from 0 to 7, are timer 1, timer 2, inverted sense, timer 3, receive ready, transmit empty, timer 4, and timer 5 or parallel bit 7. The opcode of slot i is 8'hC7 + 8*i.
- R5: When several enabled sources are pending, addrOut holds the opcode with the largest value.
- R6: The sense source requests while the sense input is low.
- R7: Command bit 7 (command written at wrAddr 6) set routes parallel bit 7 into slot 7. Clear routes timer 5 into slot 7.
- R8: ackDrive equals intAck while command bit 3 is set, and is 0 otherwise. ackData is 8'hFF while command bit 2 is set, and addrOut otherwise.
- R9: On the cycle intAck falls, the timer request in the slot held by addrOut is cleared.
- R10: A command write with bit 0 set stops all five timers, clears their requests and clears irqPending.
- R11: Rewriting a timer clears its request. A timer written with 0 never requests.
- R12: addrOut does not change while intAck is high, nor on the cycle it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Processor register write strobe |
| wrAddr | input | 3 | Register select: 0-4 timers, 5 mask, 6 command |
| wrData | input | 8 | Write data |
| tickEn | input | 1 | Timer decrement enable (one pulse per 64 us) |
| senseIn | input | 1 | Sense line, requests when low |
| rxReady | input | 1 | UART receive-data-ready flag |
| txEmpty | input | 1 | UART transmit-buffer-empty flag |
| parBit7 | input | 1 | Parallel port bit 7 |
| intAck | input | 1 | Interrupt acknowledge cycle in progress |
| irqPending | output | 1 | Interrupt request line and status pending flag |
| addrOut | output | 8 | Interrupt address register (winning opcode) |
| ackData | output | 8 | Opcode for the acknowledge cycle |
| ackDrive | output | 1 | Enable for driving ackData onto the bus |

## Verification
Directed sequences load timers with several counts and tick them up to and past their expiry. This separates an off-by-one count from a correct one, and a timer that stops at zero from one that wraps. Pairs of sources are raised under masks that hide one of them. This tells the priority rule and the mask-to-slot mapping apart from a reversed or shifted ordering. Acknowledge cycles are run with restart-7 mode and drive enable both on and off, and new requests arrive during the cycle, which exposes an address register that keeps updating or a request that is not cleared afterwards. A seeded random phase drives the level sources and the mask, and compares the pending flag and the opcode with a priority model in the bench.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NUM_TMR = 5;
  localparam int NUM_SRC = 8;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int DATA_W  = 8;
  localparam logic [2:0] MASK_ADDR = 3'd5;
  localparam logic [2:0] CMD_ADDR  = 3'd6;
  localparam int SLOT_SENSE = 2;
  localparam int SLOT_RX    = 4;
  localparam int SLOT_TX    = 5;
  localparam int SLOT_SHARE = 7;

  typedef struct packed {
    logic [NUM_TMR-1:0] tmrLoad;
    logic               maskWr;
    logic               softRst;
    logic               ackFreeze;
    logic               ackEnd;
    logic               par7Sel;
  } strobe_t;

  function automatic int timerSlot(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 3;
      3: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slotOpcode(input logic [IDX_W-1:0] idx);
    return {2'b11, idx, 3'b111};
  endfunction
endpackage

// File: rtl/irqv_timer.sv
module irqv_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [TMR_W-1:0] loadVal,
  input  logic             tick,
  input  logic             clr,
  input  logic             ackClr,
  output logic             reqOut
);
  logic [TMR_W-1:0] cntQ;
  logic             reqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      reqQ <= 1'b0;
    end else if (clr) begin
      cntQ <= '0;
      reqQ <= 1'b0;
    end else if (loadEn) begin
      cntQ <= loadVal;
      reqQ <= 1'b0;
    end else begin
      if (ackClr) reqQ <= 1'b0;
      if (tick && cntQ != '0) begin
        cntQ <= cntQ - 1'b1;
        if (cntQ == TMR_W'(1)) reqQ <= 1'b1;
      end
    end
  end

  assign reqOut = reqQ;

  AST_TMR_FIRE_AT_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqQ) |-> ($past(cntQ) == TMR_W'(1) && $past(tick)));  // R2
  AST_TMR_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == '0 && !loadEn) |=> cntQ == '0);  // R2
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [3:0]        cmdIn,
  input  logic              intAck,
  input  logic [DATA_W-1:0] addrIn,
  output strobe_t           strb,
  output logic [DATA_W-1:0] ackData,
  output logic              ackDrive
);
  logic rst7Q, ackEnQ, par7Q, ackPrevQ;
  logic cmdWr;

  assign cmdWr = wrEn && (wrAddr == CMD_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rst7Q    <= 1'b0;
      ackEnQ   <= 1'b0;
      par7Q    <= 1'b0;
      ackPrevQ <= 1'b0;
    end else begin
      ackPrevQ <= intAck;
      if (cmdWr) begin
        par7Q  <= cmdIn[3];
        ackEnQ <= cmdIn[2];
        rst7Q  <= cmdIn[1];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_TMR; k++)
      strb.tmrLoad[k] = wrEn && (wrAddr == 3'(k));
    strb.maskWr    = wrEn && (wrAddr == MASK_ADDR);
    strb.softRst   = cmdWr && cmdIn[0];
    strb.ackFreeze = intAck || ackPrevQ;
    strb.ackEnd    = ackPrevQ && !intAck;
    strb.par7Sel   = par7Q;
  end

  assign ackDrive = intAck && ackEnQ;
  assign ackData  = rst7Q ? {DATA_W{1'b1}} : addrIn;

  AST_ACK_ONLY_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ackDrive |-> intAck);  // R8
  AST_END_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackEnd |-> $past(intAck));  // R9
endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickEn,
  input  logic              senseIn,
  input  logic              rxReady,
  input  logic              txEmpty,
  input  logic              parBit7,
  output logic              irqPending,
  output logic [DATA_W-1:0] addrOut
);
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] srcVec;
  logic [NUM_SRC-1:0] masked;
  logic [NUM_TMR-1:0] tmrReq;
  logic [IDX_W-1:0]   winIdx;
  logic               pendQ;
  logic [DATA_W-1:0]  addrQ;

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    localparam int SLOT = timerSlot(k);
    logic ackHit;
    assign ackHit = strb.ackEnd && (addrQ[7:6] == 2'b11) &&
                    (addrQ[3+:IDX_W] == IDX_W'(SLOT)) &&
                    !(SLOT == SLOT_SHARE && strb.par7Sel);
    irqv_timer #(.TMR_W(TMR_W)) tmr_i (
      .clk    (clk),
      .rstN   (rstN),
      .loadEn (strb.tmrLoad[k]),
      .loadVal(wrData[TMR_W-1:0]),
      .tick   (tickEn),
      .clr    (strb.softRst),
      .ackClr (ackHit),
      .reqOut (tmrReq[k])
    );
  end

  always_comb begin
    srcVec = '0;
    for (int k = 0; k < NUM_TMR - 1; k++)
      srcVec[timerSlot(k)] = tmrReq[k];
    srcVec[SLOT_SHARE] = strb.par7Sel ? parBit7 : tmrReq[NUM_TMR-1];
    srcVec[SLOT_SENSE] = !senseIn;
    srcVec[SLOT_RX]    = rxReady;
    srcVec[SLOT_TX]    = txEmpty;
  end

  assign masked = srcVec & maskQ;

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (masked[i]) winIdx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      pendQ <= 1'b0;
      addrQ <= '0;
    end else begin
      if (strb.maskWr) maskQ <= wrData;
      pendQ <= strb.softRst ? 1'b0 : (|masked);
      if (!strb.ackFreeze && (|masked)) addrQ <= slotOpcode(winIdx);
    end
  end

  assign irqPending = pendQ;
  assign addrOut    = addrQ;

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackFreeze |=> $stable(addrQ));  // R12
  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (addrQ == '0) || (addrQ[2:0] == 3'b111 && addrQ[7:6] == 2'b11));  // R4
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> !pendQ);  // R10
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickEn,
  input  logic              senseIn,
  input  logic              rxReady,
  input  logic              txEmpty,
  input  logic              parBit7,
  input  logic              intAck,
  output logic              irqPending,
  output logic [DATA_W-1:0] addrOut,
  output logic [DATA_W-1:0] ackData,
  output logic              ackDrive
);
  strobe_t strb;

  irqv_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .cmdIn   ({wrData[7], wrData[3], wrData[2], wrData[0]}),
    .intAck  (intAck),
    .addrIn  (addrOut),
    .strb    (strb),
    .ackData (ackData),
    .ackDrive(ackDrive)
  );

  irqv_datapath #(.TMR_W(TMR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .tickEn    (tickEn),
    .senseIn   (senseIn),
    .rxReady   (rxReady),
    .txEmpty   (txEmpty),
    .parBit7   (parBit7),
    .irqPending(irqPending),
    .addrOut   (addrOut)
  );
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       tickEn = 1'b0;
  logic       senseIn = 1'b1;
  logic       rxReady = 1'b0;
  logic       txEmpty = 1'b0;
  logic       parBit7 = 1'b0;
  logic       intAck = 1'b0;
  logic       irqPending;
  logic [7:0] addrOut;
  logic [7:0] ackData;
  logic       ackDrive;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tickEn(tickEn), .senseIn(senseIn), .rxReady(rxReady), .txEmpty(txEmpty),
    .parBit7(parBit7), .intAck(intAck), .irqPending(irqPending),
    .addrOut(addrOut), .ackData(ackData), .ackDrive(ackDrive)
  );

  function automatic logic [7:0] expAddr(input logic [7:0] req, input logic [7:0] msk);
    logic [7:0] v = 8'h00;
    for (int i = 0; i < 8; i++)
      if (req[i] && msk[i]) v = 8'hC7 + 8'(8 * i);
    return v;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tickEn = 1'b1;
      @(posedge clk); #1; tickEn = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    logic [7:0] rq;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 pending", {7'b0, irqPending}, 8'h00);
    chk("R1 addr", addrOut, 8'h00);
    chk("R1 drive", {7'b0, ackDrive}, 8'h00);

    // Timer 1 count of 3
    cpuWrite(3'd5, 8'h01);
    cpuWrite(3'd0, 8'd3);
    tickN(2); settle();
    chk("R2 early", {7'b0, irqPending}, 8'h00);
    tickN(1); settle();
    chk("R2 expiry", {7'b0, irqPending}, 8'h01);
    chk("R4 timer1 opcode", addrOut, 8'hC7);

    // Timer 2 expires while masked
    cpuWrite(3'd1, 8'd1);
    tickN(1); settle();
    chk("R3 masked keeps addr", addrOut, 8'hC7);
    cpuWrite(3'd5, 8'h03); settle();
    chk("R5 highest wins", addrOut, 8'hCF);

    // Acknowledge with drive enabled
    cpuWrite(3'd6, 8'h08); settle();
    intAck = 1'b1;
    @(negedge clk);
    chk("R8 drive on", {7'b0, ackDrive}, 8'h01);
    chk("R8 vector", ackData, 8'hCF);
    rxReady = 1'b1;
    cpuWrite(3'd5, 8'h13); settle();
    chk("R12 frozen", addrOut, 8'hCF);
    intAck = 1'b0;
    settle();
    chk("R4 rx opcode after ack", addrOut, 8'hE7);
    rxReady = 1'b0;
    cpuWrite(3'd5, 8'h02); settle();
    chk("R9 timer2 cleared", {7'b0, irqPending}, 8'h00);

    // Restart-7 mode
    cpuWrite(3'd5, 8'h01); settle();
    chk("R3 timer1 still", addrOut, 8'hC7);
    cpuWrite(3'd6, 8'h0C); settle();
    intAck = 1'b1;
    @(negedge clk);
    chk("R8 rst7 vector", ackData, 8'hFF);
    intAck = 1'b0;
    settle();
    chk("R9 timer1 cleared", {7'b0, irqPending}, 8'h00);
    cpuWrite(3'd6, 8'h04);
    intAck = 1'b1;
    @(negedge clk);
    chk("R8 drive off", {7'b0, ackDrive}, 8'h00);
    intAck = 1'b0;
    settle();

    // Inverted sense
    cpuWrite(3'd5, 8'h04); settle();
    chk("R6 sense high idle", {7'b0, irqPending}, 8'h00);
    senseIn = 1'b0; settle();
    chk("R6 sense low", {7'b0, irqPending}, 8'h01);
    chk("R6 sense opcode", addrOut, 8'hD7);
    senseIn = 1'b1;

    // Shared slot 7
    cpuWrite(3'd6, 8'h80);
    parBit7 = 1'b1;
    cpuWrite(3'd5, 8'h80); settle();
    chk("R7 parallel bit", addrOut, 8'hFF);
    cpuWrite(3'd6, 8'h00); settle();
    chk("R7 timer5 routed", {7'b0, irqPending}, 8'h00);
    cpuWrite(3'd4, 8'd2);
    tickN(2); settle();
    chk("R7 timer5 fires", {7'b0, irqPending}, 8'h01);
    parBit7 = 1'b0;

    // Soft reset
    cpuWrite(3'd2, 8'd1);
    cpuWrite(3'd5, 8'hFF);
    tickN(1); settle();
    chk("R10 before", {7'b0, irqPending}, 8'h01);
    cpuWrite(3'd6, 8'h01); settle();
    chk("R10 cleared", {7'b0, irqPending}, 8'h00);
    tickN(3); settle();
    chk("R10 timers stopped", {7'b0, irqPending}, 8'h00);

    // Reload and zero load
    cpuWrite(3'd3, 8'd1);
    tickN(1); settle();
    chk("R4 timer4 opcode", addrOut, 8'hF7);
    cpuWrite(3'd3, 8'd5); settle();
    chk("R11 reload clears", {7'b0, irqPending}, 8'h00);
    cpuWrite(3'd3, 8'd0);
    tickN(2); settle();
    chk("R11 zero load", {7'b0, irqPending}, 8'h00);

    // Random level sources with random masks
    cpuWrite(3'd6, 8'h80);
    for (int it = 0; it < 40; it++) begin
      m = 8'($urandom);
      senseIn = 1'($urandom); rxReady = 1'($urandom);
      txEmpty = 1'($urandom); parBit7 = 1'($urandom);
      cpuWrite(3'd5, m); settle();
      rq = {parBit7, 1'b0, txEmpty, rxReady, 1'b0, !senseIn, 2'b00};
      chk("R3 random pending", {7'b0, irqPending}, {7'b0, |(rq & m)});
      if (|(rq & m)) chk("R5 random opcode", addrOut, expAddr(rq, m));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule